// File: doc/BRIEF.md
# Constant-Result Writeback Filter

This block sits between the execute-stage writeback bus and the physical register file of an out-of-order core. Every completed result is inspected; when it equals exactly 0 or exactly 1, no register is written. Instead, the physical register that rename handed out for that destination goes back to the external free list. The rename table is told to point that destination at one of two reserved tags. Dependents are woken with that reserved tag. All other results are written into the register file as usual and woken with their own tag.

The block also owns the register-file read ports. A read of a reserved tag returns the constant it stands for and does not touch the storage array. Two small per-cycle counts report how many writes and reads were avoided. With a tag width `TAG_W`, the codes `2^TAG_W-2` (constant 0) and `2^TAG_W-1` (constant 1) are reserved. The outside world must never put them on the free list or hand them out at rename.

Top module: `rzc_wb_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rel_valid`, `wake_valid`, `wr_saved` and `rd_saved` are 0, whatever the inputs carry.
- R2: A writeback of value 0 to a non-reserved tag T gives, one cycle later, `rel_valid`=1, `rel_tag`=T, `rel_new_tag`=2^TAG_W-2, `wake_valid`=1 and `wake_tag`=2^TAG_W-2.
- R3: A writeback of value 1 to a non-reserved tag T gives the same release one cycle later, with `rel_new_tag` and `wake_tag` both equal to 2^TAG_W-1. This includes the highest non-reserved tag.
- R4: A writeback of any other value to a non-reserved tag T gives no release, `wake_valid`=1 and `wake_tag`=T one cycle later. The value is stored, and a later read of T returns it.
- R5: A 0 or 1 writeback does not write the register file: a later read of T returns the value T held before.
- R6: A read with `rd_en` set and tag 2^TAG_W-2 returns all zeros one cycle later. With tag 2^TAG_W-1 it returns 1 zero-extended to `DATA_W`.
- R7: A read with `rd_en` set and a non-reserved tag returns that register's stored value one cycle later. Port i uses bits [i*TAG_W +: TAG_W] of `rd_tag` and [i*DATA_W +: DATA_W] of `rd_data`.
- R8: `wr_saved` is 1 in the cycle after a writeback that caused a release, and 0 otherwise, including idle cycles and normal writebacks.
- R9: `rd_saved` equals, one cycle later, the number of ports whose `rd_en` was set with a reserved tag.
- R10: A writeback whose tag is reserved never releases a register and never writes storage, whatever its value. It still wakes with its own tag, and reads of that reserved tag keep returning the constant.
- R11: Only values exactly equal to 0 or 1 are treated as constants. Values such as 2, or 1 with high bits set, are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | Writeback present this cycle |
| wb_tag | input | TAG_W | Physical destination tag assigned at rename |
| wb_data | input | DATA_W | Result value |
| rd_en | input | NUM_RD | Per-port read enable |
| rd_tag | input | NUM_RD*TAG_W | Per-port read tags, port i at [i*TAG_W +: TAG_W] |
| rd_data | output | NUM_RD*DATA_W | Per-port read data, one cycle after the request |
| rel_valid | output | 1 | Destination register released and remapped |
| rel_tag | output | TAG_W | Register to return to the free list |
| rel_new_tag | output | TAG_W | Reserved tag the rename table must map the destination to |
| wake_valid | output | 1 | Wakeup broadcast valid |
| wake_tag | output | TAG_W | Tag broadcast to dependents |
| wr_saved | output | 1 | A register write was avoided last cycle |
| rd_saved | output | $clog2(NUM_RD+1) | Number of register reads avoided last cycle |

## Verification
The writeback path is driven with exact zeros and ones and with near misses (2, 1 with the top bit set, all ones). Only the exact values may trigger a release, so this separates a full-width compare from one that looks at the low bits. A constant result aimed at a register that already holds data, followed by a read of that register, shows whether the write was truly suppressed rather than only reported. Reads pair both reserved tags, a mix of reserved and normal tags, and two normal tags, which checks the constant mux per port and the avoided-read count. Writebacks aimed at the reserved tags themselves check that those codes are never released and never written.

// File: rtl/rzc_pkg.sv
package rzc_pkg;
  // Code of the reserved tag that stands for constant 0; the next code stands for 1.
  function automatic int unsigned zero_code(input int unsigned tag_w);
    return (32'd1 << tag_w) - 32'd2;
  endfunction
endpackage

// File: rtl/rzc_classify.sv
module rzc_classify #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              rel_valid,
  output logic [TAG_W-1:0]  rel_tag,
  output logic [TAG_W-1:0]  rel_new_tag,
  output logic              wake_valid,
  output logic [TAG_W-1:0]  wake_tag,
  output logic              wr_saved
);
  localparam logic [TAG_W-1:0] ZERO_TAG = TAG_W'(rzc_pkg::zero_code(TAG_W));
  localparam logic [TAG_W-1:0] ONE_TAG  = ZERO_TAG + TAG_W'(1);

  logic is_zero, is_one, is_res, hit;
  logic [TAG_W-1:0] const_tag;

  always_comb begin
    is_zero   = (wb_data == '0);
    is_one    = (wb_data == DATA_W'(1));
    is_res    = (wb_tag >= ZERO_TAG);
    hit       = wb_valid && (is_zero || is_one) && !is_res;
    const_tag = is_one ? ONE_TAG : ZERO_TAG;
    wr_en     = wb_valid && !(is_zero || is_one) && !is_res;
    wr_tag    = wb_tag;
    wr_data   = wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid  <= 1'b0;
      wake_valid <= 1'b0;
      wr_saved   <= 1'b0;
    end else begin
      rel_valid  <= hit;
      wake_valid <= wb_valid;
      wr_saved   <= hit;
    end
    rel_tag     <= wb_tag;
    rel_new_tag <= const_tag;
    wake_tag    <= hit ? const_tag : wb_tag;
  end

  // R10: a released register is never one of the reserved codes
  p_rel_not_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_tag < ZERO_TAG));
  // R2: an exact zero on a normal tag is released toward the zero tag
  p_zero_release_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_data == '0 && wb_tag < ZERO_TAG) |=>
      (rel_valid && rel_new_tag == ZERO_TAG && wake_tag == ZERO_TAG));
  // R3: an exact one on a normal tag is released toward the one tag
  p_one_release_r3: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_data == DATA_W'(1) && wb_tag < ZERO_TAG) |=>
      (rel_valid && rel_new_tag == ONE_TAG && wake_tag == ONE_TAG));
  // R4: a released writeback still wakes its dependents
  p_release_wakes_r4: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> wake_valid);
endmodule

// File: rtl/rzc_bank.sv
module rzc_bank #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << TAG_W;
  localparam logic [TAG_W-1:0] ZERO_TAG = TAG_W'(rzc_pkg::zero_code(TAG_W));
  localparam logic [TAG_W-1:0] ONE_TAG  = ZERO_TAG + TAG_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] raw_q;
  logic              cst_q, cst_bit_q;
  logic              rd_res;

  assign rd_res = (rd_tag >= ZERO_TAG);

  // Storage path kept free of reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tag] <= wr_data;
    if (rd_en && !rd_res) raw_q <= mem[rd_tag];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cst_q     <= 1'b0;
      cst_bit_q <= 1'b0;
    end else if (rd_en) begin
      cst_q     <= rd_res;
      cst_bit_q <= (rd_tag == ONE_TAG);
    end
  end

  assign rd_data = cst_q ? {{(DATA_W-1){1'b0}}, cst_bit_q} : raw_q;

  // R10: storage never receives a write to a reserved code
  p_no_reserved_write_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_tag < ZERO_TAG));
  // R6: reserved reads return the constant one cycle later
  p_const_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_res) |=> (rd_data == DATA_W'($past(rd_tag) == ONE_TAG)));
endmodule

// File: rtl/rzc_wb_filter.sv
module rzc_wb_filter #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int NUM_RD = 2,
  localparam int CNT_W = $clog2(NUM_RD + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wb_valid,
  input  logic [TAG_W-1:0]         wb_tag,
  input  logic [DATA_W-1:0]        wb_data,
  input  logic [NUM_RD-1:0]        rd_en,
  input  logic [NUM_RD*TAG_W-1:0]  rd_tag,
  output logic [NUM_RD*DATA_W-1:0] rd_data,
  output logic                     rel_valid,
  output logic [TAG_W-1:0]         rel_tag,
  output logic [TAG_W-1:0]         rel_new_tag,
  output logic                     wake_valid,
  output logic [TAG_W-1:0]         wake_tag,
  output logic                     wr_saved,
  output logic [CNT_W-1:0]         rd_saved
);
  localparam logic [TAG_W-1:0] ZERO_TAG = TAG_W'(rzc_pkg::zero_code(TAG_W));

  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  rd_cnt;

  rzc_classify #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cls (
    .clk(clk), .rst(rst),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_new_tag(rel_new_tag),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .wr_saved(wr_saved)
  );

  // One bank copy per read port; all copies see the same write.
  for (genvar i = 0; i < NUM_RD; i++) begin : g_port
    rzc_bank #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
      .rd_en(rd_en[i]), .rd_tag(rd_tag[i*TAG_W +: TAG_W]),
      .rd_data(rd_data[i*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    rd_cnt = '0;
    for (int i = 0; i < NUM_RD; i++)
      if (rd_en[i] && rd_tag[i*TAG_W +: TAG_W] >= ZERO_TAG) rd_cnt = rd_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_saved <= '0;
    else     rd_saved <= rd_cnt;
  end

  // R9: avoided reads never exceed the port count
  p_rd_saved_bound_r9: assert property (@(posedge clk) disable iff (rst)
    rd_saved <= CNT_W'(NUM_RD));
  // R9: no enabled port means nothing avoided in the next cycle
  p_rd_saved_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en == '0) |=> (rd_saved == '0));
  // R8: an avoided write always comes with a release
  p_saved_has_release_r8: assert property (@(posedge clk) disable iff (rst)
    wr_saved |-> rel_valid);
endmodule

// File: tb/rzc_wb_filter_test.sv
module rzc_wb_filter_test;
  localparam int DW = 32, TW = 6, NR = 2;
  localparam logic [TW-1:0] ZT = 6'd62, OT = 6'd63;

  logic clk = 0, rst = 1;
  logic wb_valid = 0;
  logic [TW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_data = '0;
  logic [NR-1:0] rd_en = '0;
  logic [NR*TW-1:0] rd_tag = '0;
  logic [NR*DW-1:0] rd_data;
  logic rel_valid, wake_valid, wr_saved;
  logic [TW-1:0] rel_tag, rel_new_tag, wake_tag;
  logic [1:0] rd_saved;

  always #2 clk = ~clk;

  rzc_wb_filter #(.DATA_W(DW), .TAG_W(TW), .NUM_RD(NR)) uut (.*);

  typedef struct {
    bit rv; logic [TW-1:0] rt, rn;
    bit wv; logic [TW-1:0] wt;
    bit ws; int rs;
    bit chk0, chk1; logic [DW-1:0] d0, d1;
    string req;
  } exp_t;

  exp_t sb[$];
  logic [DW-1:0] shadow [64];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic logic [DW-1:0] rd_model(logic [TW-1:0] t);
    if (t == ZT) return '0;
    if (t == OT) return 32'd1;
    return shadow[t];
  endfunction

  task automatic step(input bit v, input logic [TW-1:0] t, input logic [DW-1:0] d,
                      input bit e0, input logic [TW-1:0] t0,
                      input bit e1, input logic [TW-1:0] t1, input string req);
    exp_t x;
    bit cst, res, hit;
    @(negedge clk);
    wb_valid = v; wb_tag = t; wb_data = d;
    rd_en = {e1, e0}; rd_tag = {t1, t0};
    cst = (d == 0) || (d == 1);
    res = (t >= ZT);
    hit = v && cst && !res;
    x.rv = hit; x.rt = t; x.rn = (d == 1) ? OT : ZT;
    x.wv = v; x.wt = hit ? x.rn : t;
    x.ws = hit;
    x.rs = int'(e0 && t0 >= ZT) + int'(e1 && t1 >= ZT);
    x.chk0 = e0; x.d0 = rd_model(t0);
    x.chk1 = e1; x.d1 = rd_model(t1);
    x.req = req;
    if (rst) begin
      x.rv = 0; x.wv = 0; x.ws = 0; x.rs = 0; x.chk0 = 0; x.chk1 = 0;
    end else if (v && !cst && !res) shadow[t] = d;
    sb.push_back(x);
  endtask

  // Monitor: one expected item per cycle, compared 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t x;
        bit bad;
        x = sb.pop_front();
        vectors++;
        bad = (rel_valid !== x.rv) || (x.rv && (rel_tag !== x.rt || rel_new_tag !== x.rn))
           || (wake_valid !== x.wv) || (x.wv && wake_tag !== x.wt)
           || (wr_saved !== x.ws) || (int'(rd_saved) != x.rs)
           || (x.chk0 && rd_data[DW-1:0] !== x.d0) || (x.chk1 && rd_data[2*DW-1:DW] !== x.d1);
        if (bad) begin
          miscompares++;
          $display("FAIL %s: got rel=%b/%0d/%0d wake=%b/%0d ws=%b rs=%0d rd=%h,%h exp rel=%b/%0d/%0d wake=%b/%0d ws=%b rs=%0d rd=%h,%h",
                   x.req, rel_valid, rel_tag, rel_new_tag, wake_valid, wake_tag, wr_saved, rd_saved,
                   rd_data[DW-1:0], rd_data[2*DW-1:DW],
                   x.rv, x.rt, x.rn, x.wv, x.wt, x.ws, x.rs, x.d0, x.d1);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates live-looking inputs
    step(1, 6'd3, 32'd0, 1, ZT, 1, OT, "R1 reset");
    step(1, 6'd4, 32'd1, 0, 0, 0, 0, "R1 reset");
    @(negedge clk); rst = 0;
    wb_valid = 0; rd_en = '0;
    step(0, 0, 0, 0, 0, 0, 0, "R1 first cycle");
    // R4 / R11: normal writes, including near-miss values
    step(1, 6'd5, 32'hDEADBEEF, 0, 0, 0, 0, "R4 normal write");
    step(1, 6'd6, 32'd2, 0, 0, 0, 0, "R11 value 2");
    step(1, 6'd7, 32'h80000001, 0, 0, 0, 0, "R11 one with top bit");
    step(1, 6'd0, 32'hFFFFFFFF, 0, 0, 0, 0, "R4 all ones");
    step(0, 0, 0, 0, 0, 0, 0, "R8 idle");
    // R7: normal reads on both ports
    step(0, 0, 0, 1, 6'd5, 1, 6'd6, "R7 read normal");
    step(0, 0, 0, 1, 6'd7, 1, 6'd0, "R7 read normal");
    // R2 / R5: zero result onto a register holding data
    step(1, 6'd5, 32'd0, 0, 0, 0, 0, "R2 zero release");
    step(0, 0, 0, 1, 6'd5, 0, 0, "R5 no write on zero");
    // R3 / R5: one result, and at the highest normal tag
    step(1, 6'd7, 32'd1, 0, 0, 0, 0, "R3 one release");
    step(1, 6'd61, 32'd1, 1, 6'd7, 0, 0, "R3 top normal tag / R5");
    step(1, 6'd9, 32'd0, 0, 0, 0, 0, "R2 zero release");
    // R6 / R9: reserved reads
    step(0, 0, 0, 1, ZT, 1, OT, "R6 R9 both reserved");
    step(0, 0, 0, 1, OT, 1, 6'd5, "R6 R9 mixed");
    step(0, 0, 0, 1, 6'd6, 1, ZT, "R6 R9 mixed");
    // R10: writebacks aimed at the reserved codes
    step(1, OT, 32'd0, 0, 0, 0, 0, "R10 reserved tag zero");
    step(1, ZT, 32'd55, 0, 0, 0, 0, "R10 reserved tag data");
    step(1, OT, 32'h1234, 1, ZT, 1, OT, "R10 reserved unchanged");
    step(0, 0, 0, 1, ZT, 1, OT, "R10 reserved reads");
    // R8: normal write after releases clears the saved flag
    step(1, 6'd12, 32'h42, 0, 0, 0, 0, "R8 normal write");
    step(0, 0, 0, 1, 6'd12, 0, 0, "R4 readback");
    step(0, 0, 0, 0, 0, 0, 0, "R8 idle");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule